// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

The block arbitrates five interrupt request sources for a CPU core. The sources are external 0, timer 0 overflow, external 1, timer 1 overflow and a combined serial receive/transmit request. A byte-wide enable register holds one mask bit per source and a global mask bit. A byte-wide priority register assigns each source to the high or the low level. Software writes and reads both registers over a simple register bus. The read port is combinational.

Every cycle the block looks at the live request lines, the masks, the priorities and the in-service state. From these it presents at most one vector request to the CPU. The request pair `irq_valid`/`irq_ack` works as a valid/ready handshake. A grant counts as taken only in a cycle where both are high. Unlike a buffered stream, the offer is not held: `irq_valid` and `irq_vector` may change or drop from one cycle to the next while no acknowledge has been given, because requests are never latched. The CPU must sample the vector in the same cycle it acknowledges.

On a taken grant the block marks the granted level as in service. A return-from-interrupt pulse ends the innermost routine. This supports nesting one high-level routine inside one low-level routine.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset both registers read 0x00 and `irq_valid` is 0.
- R2: `reg_addr`=0 selects the enable register and `reg_addr`=1 selects the priority register. A write with `reg_wr`=1 takes effect at the next rising edge, and `reg_rdata` shows the selected register combinationally. The reserved enable bits 6:5 and priority bits 7:5 always read 0, and writes to them are ignored.
- R3: When enable bit 7 (global mask) is 0, `irq_valid` stays 0 for any request pattern.
- R4: Enable and priority bits 0..4 belong to external 0, timer 0, external 1, timer 1 and serial, in that order. A source whose enable bit is 0 is never granted.
- R5: A priority bit of 1 places the source at the high level. Any pending eligible high-level request wins over every low-level one, whatever their poll positions.
- R6: Within a level, the lowest source index wins. `irq_vector` is 0x0003 + 8·index (0x0003, 0x000B, 0x0013, 0x001B, 0x0023). `irq_level` is 1 for a high-level grant. `irq_vector` is 0 when `irq_valid` is 0.
- R7: While only a low-level routine is in service, only high-level requests are offered.
- R8: While a high-level routine is in service, `irq_valid` is 0.
- R9: `irq_ack` in a cycle with `irq_valid`=1 marks the level given by `irq_level` as in service from the next edge on. `irq_ack` with `irq_valid`=0 has no effect.
- R10: `irq_reti` clears the high in-service flag if it is set, else the low one. If `irq_reti` and a taken grant fall in the same cycle, the clear acts on the flags held before that edge, and the new flag is then set.
- R11: Requests are not latched. A source that drops its line withdraws its offer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = enable register, 1 = priority register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| src_req | input | 5 | Live request lines, bit order as in R4 |
| irq_valid | output | 1 | Vector request to the CPU |
| irq_vector | output | 16 | Service address of the offered source |
| irq_level | output | 1 | 1 when the offered grant is high level |
| irq_ack | input | 1 | CPU accepts the offered vector |
| irq_reti | input | 1 | Return from the current service routine |

## Verification
The case that needs care is an acknowledge and a return-from-interrupt in the same cycle. The bench reaches it by taking a low-level grant first, then raising a high-level request and driving `irq_ack` and `irq_reti` together. The expected result is that the old low flag is cleared and the new high flag is set. This is judged at the ports: the offer must go quiet while the high routine runs. After one more return, a low request must be granted again, which shows that no stale low flag remains.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NSRC     = 5;
  localparam int DW       = 8;
  localparam int VW       = 16;
  localparam int EA_BIT   = 7;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int NLVL     = 2;
  localparam int LVL_LO   = 0;
  localparam int LVL_HI   = 1;

  function automatic logic [VW-1:0] vec_of(input int idx);
    return VW'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int P_DW     = DW,
  parameter int P_NSRC   = NSRC,
  parameter int P_EA_BIT = EA_BIT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [P_DW-1:0]   wdata,
  output logic [P_DW-1:0]   rdata,
  output logic              ea,
  output logic [P_NSRC-1:0] src_en,
  output logic [P_NSRC-1:0] src_hi
);
  localparam logic [P_DW-1:0] SRC_MASK = P_DW'((1 << P_NSRC) - 1);
  localparam logic [P_DW-1:0] EN_MASK  = SRC_MASK | P_DW'(1 << P_EA_BIT);
  localparam logic [P_DW-1:0] PRI_MASK = SRC_MASK;

  logic [P_DW-1:0] en_q;
  logic [P_DW-1:0] pri_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      pri_q <= '0;
    end else if (wr) begin
      if (addr) pri_q <= wdata & PRI_MASK;
      else      en_q  <= wdata & EN_MASK;
    end
  end

  assign rdata  = addr ? pri_q : en_q;
  assign ea     = en_q[P_EA_BIT];
  assign src_en = en_q[P_NSRC-1:0];
  assign src_hi = pri_q[P_NSRC-1:0];

  AST_RSV_EN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr) |=> ((en_q & ~EN_MASK) == '0)); // R2
  AST_RSV_PRI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr) |=> ((pri_q & ~PRI_MASK) == '0)); // R2
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(en_q) && $stable(pri_q))); // R2
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int P_NSRC = NSRC,
  parameter int P_VW   = VW
) (
  input  logic [P_NSRC-1:0] pend,
  output logic              found,
  output logic [P_VW-1:0]   vector
);
  logic [P_NSRC-1:0] win;

  always_comb begin
    win    = '0;
    vector = '0;
    for (int i = P_NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win    = '0;
        win[i] = 1'b1;
        vector = vec_of(i);
      end
    end
  end

  assign found = |pend;

  always_comb begin
    AST_ONE_WINNER: assert ($onehot0(win)); // R6
    AST_WIN_PENDING: assert ((win & ~pend) == '0); // R6
  end
endmodule

// File: rtl/irqc_inservice.sv
module irqc_inservice (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic isr_hi,
  output logic isr_lo
);
  logic hi_q, lo_q;
  logic clr_hi, clr_lo;

  assign clr_hi = ret & hi_q;
  assign clr_lo = ret & ~hi_q & lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= (hi_q & ~clr_hi) | (take & take_hi);
      lo_q <= (lo_q & ~clr_lo) | (take & ~take_hi);
    end
  end

  assign isr_hi = hi_q;
  assign isr_lo = lo_q;

  AST_TAKE_SETS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_hi) |=> isr_hi); // R9
  AST_TAKE_SETS_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !take_hi) |=> isr_lo); // R9
  AST_RET_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && isr_hi && !take) |=> (!isr_hi && $stable(isr_lo))); // R10
  AST_RET_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !isr_hi && !take) |=> !isr_lo); // R10
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] src_req,
  output logic            irq_valid,
  output logic [VW-1:0]   irq_vector,
  output logic            irq_level,
  input  logic            irq_ack,
  input  logic            irq_reti
);
  logic            ea;
  logic [NSRC-1:0] src_en, src_hi, eligible;
  logic [NSRC-1:0] pend [NLVL];
  logic [NLVL-1:0] found;
  logic [VW-1:0]   lvl_vec [NLVL];
  logic            isr_hi, isr_lo;
  logic            grant_hi, grant_lo, take;

  irqc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .ea(ea), .src_en(src_en), .src_hi(src_hi)
  );

  assign eligible     = src_req & src_en & {NSRC{ea}};
  assign pend[LVL_HI] = eligible & src_hi;
  assign pend[LVL_LO] = eligible & ~src_hi;

  for (genvar lv = 0; lv < NLVL; lv++) begin : g_lvl
    irqc_pick u_pick (
      .pend(pend[lv]), .found(found[lv]), .vector(lvl_vec[lv])
    );
  end

  assign grant_hi = ~isr_hi & found[LVL_HI];
  assign grant_lo = ~isr_hi & ~isr_lo & ~found[LVL_HI] & found[LVL_LO];

  assign irq_valid  = grant_hi | grant_lo;
  assign irq_level  = grant_hi;
  assign irq_vector = grant_hi ? lvl_vec[LVL_HI] :
                      grant_lo ? lvl_vec[LVL_LO] : '0;
  assign take       = irq_valid & irq_ack;

  irqc_inservice u_isr (
    .clk(clk), .rst_n(rst_n), .take(take), .take_hi(irq_level),
    .ret(irq_reti), .isr_hi(isr_hi), .isr_lo(isr_lo)
  );

  AST_EA_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq_valid); // R3
  AST_ENABLE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((src_req & src_en) != '0)); // R4
  AST_LO_ONLY_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_lo && irq_valid) |-> irq_level); // R7
  AST_HI_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    isr_hi |-> !irq_valid); // R8
  AST_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (src_req != '0)); // R11
  AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_vector == '0)); // R6
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {enable, priority, requests, exp_valid, exp_vector, exp_level}
  localparam logic [38:0] VT [NV] = '{
    {8'h9F, 8'h00, 5'h1F, 1'b1, 16'h0003, 1'b0},
    {8'h9F, 8'h00, 5'h1E, 1'b1, 16'h000B, 1'b0},
    {8'h9F, 8'h00, 5'h18, 1'b1, 16'h001B, 1'b0},
    {8'h9F, 8'h10, 5'h1F, 1'b1, 16'h0023, 1'b1},
    {8'h9F, 8'h0C, 5'h0D, 1'b1, 16'h0013, 1'b1},
    {8'h1F, 8'h00, 5'h1F, 1'b0, 16'h0000, 1'b0},
    {8'h94, 8'h00, 5'h0B, 1'b0, 16'h0000, 1'b0},
    {8'h94, 8'h00, 5'h14, 1'b1, 16'h0013, 1'b0},
    {8'h9F, 8'h1F, 5'h10, 1'b1, 16'h0023, 1'b1},
    {8'h9F, 8'h01, 5'h00, 1'b0, 16'h0000, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_addr = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [4:0]  src_req = '0;
  logic        irq_valid;
  logic [15:0] irq_vector;
  logic        irq_level;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_level(irq_level),
    .irq_ack(irq_ack), .irq_reti(irq_reti)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1 chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic set_req(input logic [4:0] r);
    @(negedge clk);
    src_req = r;
    #1;
  endtask

  task automatic pulse(input logic ack, input logic ret);
    @(negedge clk);
    irq_ack = ack; irq_reti = ret;
    @(negedge clk);
    irq_ack = 1'b0; irq_reti = 1'b0;
    #1;
  endtask

  task automatic chk_offer(input string tag, input logic v, input logic [15:0] vec, input logic lvl);
    chk({tag, " valid"}, 32'(irq_valid), 32'(v));
    chk({tag, " vector"}, 32'(irq_vector), 32'(vec));
    if (v) chk({tag, " level"}, 32'(irq_level), 32'(lvl));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 offer after reset", 32'(irq_valid), 0);
    rd_chk("R1 enable reset", 1'b0, 8'h00);
    rd_chk("R1 priority reset", 1'b1, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [7:0] en, pr;
      logic [4:0] rq;
      logic ev, el;
      logic [15:0] evec;
      {en, pr, rq, ev, evec, el} = VT[i];
      wr_reg(1'b0, en);
      wr_reg(1'b1, pr);
      set_req(rq);
      chk_offer($sformatf("R3 R4 R5 R6 vector %0d", i), ev, evec, el);
    end

    wr_reg(1'b0, 8'hFF);
    rd_chk("R2 enable reserved", 1'b0, 8'h9F);
    wr_reg(1'b1, 8'hFF);
    rd_chk("R2 priority reserved", 1'b1, 8'h1F);

    wr_reg(1'b1, 8'h00);
    set_req(5'h02);
    chk_offer("R11 live request", 1'b1, 16'h000B, 1'b0);
    set_req(5'h00);
    chk_offer("R11 withdrawn", 1'b0, 16'h0000, 1'b0);

    pulse(1'b1, 1'b0);
    set_req(5'h01);
    chk_offer("R9 idle ack ignored", 1'b1, 16'h0003, 1'b0);

    wr_reg(1'b1, 8'h04);
    pulse(1'b1, 1'b0);
    chk_offer("R7 low blocks low", 1'b0, 16'h0000, 1'b0);
    set_req(5'h05);
    chk_offer("R7 high preempts", 1'b1, 16'h0013, 1'b1);
    pulse(1'b1, 1'b0);
    chk_offer("R8 high busy", 1'b0, 16'h0000, 1'b0);
    pulse(1'b0, 1'b1);
    chk_offer("R10 reti clears high", 1'b1, 16'h0013, 1'b1);
    set_req(5'h01);
    chk_offer("R10 low still busy", 1'b0, 16'h0000, 1'b0);
    pulse(1'b0, 1'b1);
    chk_offer("R10 reti clears low", 1'b1, 16'h0003, 1'b0);

    pulse(1'b1, 1'b0);
    set_req(5'h05);
    chk_offer("R7 offer before joint", 1'b1, 16'h0013, 1'b1);
    pulse(1'b1, 1'b1);
    chk_offer("R10 joint ack reti", 1'b0, 16'h0000, 1'b0);
    pulse(1'b0, 1'b1);
    set_req(5'h01);
    chk_offer("R10 no stale low", 1'b1, 16'h0003, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule